// File: doc/BRIEF.md
# Table-Mixing Pseudo-Random Word Generator

This core produces a stream of 32-bit pseudo-random words from a 64-entry table of 32-bit state words and two accumulators. Each output step takes five clock cycles. The step stirs the first accumulator with a shift-XOR pattern and adds a word taken from the opposite half of the table. It reads the current state word and uses that word to pick a second table entry. It then forms a new state word, uses that new word to pick a third entry, and produces the next result word. The new state word goes back into the table in place of the current one.

Software or a controller first fills the table through the seed port while the core is idle. It then raises `run`. While `run` stays high the core produces one result every five cycles, with a single-cycle `rnd_valid` strobe. The table write of each step is posted and only lands during the following step. Because of that, both indirect lookups compare their index with the word that is still in flight and take it directly when the indices match.

Top module: `isaac_core`

## Requirements
- R1: Reset clears the step index, both accumulators, `rnd_valid` and `rnd_data` to zero, and leaves the table contents untouched.
- R2: While the core is idle (no step in progress, `run` low, no posted write outstanding), `seed_we` writes `seed_data` into entry `seed_addr`.
- R3: `seed_we` has no effect while a step is in progress or `run` is high.
- R4: A step lasts exactly five cycles. `rnd_valid` is high for one cycle at the end of each step, so continuous running yields one result every five cycles.
- R5: At the start of step i the accumulator A is mixed as A ^ (A << 13), A ^ (A >> 6), A ^ (A << 2) or A ^ (A >> 16) for i mod 4 equal to 0, 1, 2 or 3.
- R6: The new A is the mixed A plus table entry (i + 32) mod 64.
- R7: With X = entry i, the new state word is Y = B + A + entry X[7:2].
- R8: If X[7:2] names the entry written by the previous step, that step's Y is used even though its table write has not yet landed.
- R9: The new B is X + entry Y[13:8], and when Y[13:8] equals i the fresh Y is used in place of the old entry i.
- R10: Entry i is replaced with Y, and `rnd_data` presents the new B together with the `rnd_valid` strobe.
- R11: The step index advances by one after every step and wraps from 63 to 0.
- R12: `run` is sampled only between steps: a started step always completes, and with `run` low no further step begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_we | input | 1 | Table seed write strobe |
| seed_addr | input | 6 | Table entry to seed |
| seed_data | input | 32 | Seed word |
| run | input | 1 | Keep producing results while high |
| rnd_valid | output | 1 | One-cycle strobe per finished step |
| rnd_data | output | 32 | Result word of the last step |

## Verification
The hardest states to reach are the two forwarding hazards. In these, a lookup index derived from data equals the entry whose write is still posted (previous step) or not yet issued (current step). A general seed pattern reaches them only by chance. The bench therefore builds two dedicated seed tables. In the first, entry 1 has index bits 7:2 equal to zero, so step 1 must forward step 0's word. In the second, the first step's new word is 0x10, so its bits 13:8 point back at entry 0. Runs of 70 steps also carry the index across its wrap and through all four shift modes, and every result is compared with an in-place reference model.

// File: rtl/isaac_core.sv
module isaac_core #(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_we,
  input  logic [AW-1:0] seed_addr,
  input  logic [W-1:0]  seed_data,
  input  logic          run,
  output logic          rnd_valid,
  output logic [W-1:0]  rnd_data
);
  localparam int N = 1 << AW;

  logic [W-1:0]  mem [N];
  logic [2:0]    ph;
  logic [AW-1:0] idx, pidx;
  logic          pend;
  logic [W-1:0]  acc_a, acc_b, xw, y1, yw, py, mixed;

  wire [AW-1:0] idx_far = {~idx[AW-1], idx[AW-2:0]};
  wire [AW-1:0] lk1     = xw[AW+1:2];
  wire [AW-1:0] lk2     = yw[AW+7:8];
  wire          fwd1    = pend && (lk1 == pidx);
  wire          fwd2    = (lk2 == idx);
  wire [W-1:0]  m3      = fwd1 ? py : mem[lk1];
  wire [W-1:0]  m4      = fwd2 ? yw : mem[lk2];
  wire          idle    = (ph == 3'd0) && !run;
  wire          commit  = pend && ((ph == 3'd1) || idle);
  wire          seed_ok = seed_we && idle && !pend;

  always_comb begin
    case (idx[1:0])
      2'd0:    mixed = acc_a ^ (acc_a << 13);
      2'd1:    mixed = acc_a ^ (acc_a >> 6);
      2'd2:    mixed = acc_a ^ (acc_a << 2);
      default: mixed = acc_a ^ (acc_a >> 16);
    endcase
  end

  always_ff @(posedge clk) begin
    if (commit)       mem[pidx]      <= py;
    else if (seed_ok) mem[seed_addr] <= seed_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= '0;
      idx       <= '0;
      pidx      <= '0;
      pend      <= 1'b0;
      acc_a     <= '0;
      acc_b     <= '0;
      xw        <= '0;
      y1        <= '0;
      yw        <= '0;
      py        <= '0;
      rnd_valid <= 1'b0;
      rnd_data  <= '0;
    end else begin
      rnd_valid <= (ph == 3'd4);
      if (ph == 3'd3)  pend <= 1'b1;
      else if (commit) pend <= 1'b0;
      case (ph)
        3'd0: if (run) begin
          acc_a <= mixed + mem[idx_far];
          xw    <= mem[idx];
          ph    <= 3'd1;
        end
        3'd1: begin
          y1 <= acc_a + m3;
          ph <= 3'd2;
        end
        3'd2: begin
          yw <= acc_b + y1;
          ph <= 3'd3;
        end
        3'd3: begin
          acc_b <= xw + m4;
          py    <= yw;
          pidx  <= idx;
          ph    <= 3'd4;
        end
        default: begin
          rnd_data <= acc_b;
          idx      <= idx + 1'b1;
          ph       <= 3'd0;
        end
      endcase
    end
  end
endmodule

// File: rtl/isaac_core_chk.sv
module isaac_core_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [2:0]    ph,
  input logic [AW-1:0] idx,
  input logic          pend,
  input logic          rnd_valid
);
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= 3'd4); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |=> !rnd_valid); // R4
  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rnd_valid) |-> $past(ph) == 3'd4); // R4
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rnd_valid) |-> idx == $past(idx) + AW'(1)); // R11
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rnd_valid |-> $stable(idx)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd0 && !run) |=> ph == 3'd0); // R12
  AST_STEP_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 3'd0 && ph != 3'd4) |=> ph == $past(ph) + 3'd1); // R12
  AST_POSTED_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd2) |-> !pend); // R8
endmodule

bind isaac_core isaac_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .ph(ph),
  .idx(idx), .pend(pend), .rnd_valid(rnd_valid)
);

// File: tb/tb_isaac_core.sv
module tb_isaac_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_we = 1'b0;
  logic [5:0]  seed_addr = '0;
  logic [31:0] seed_data = '0;
  logic        run = 1'b0;
  logic        rnd_valid;
  logic [31:0] rnd_data;

  int tests = 0;
  int fails = 0;
  logic [31:0] rm [64];
  logic [31:0] ra, rb;
  int ri;

  always #2 clk = ~clk;

  isaac_core dut (.clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_addr(seed_addr),
                  .seed_data(seed_data), .run(run), .rnd_valid(rnd_valid), .rnd_data(rnd_data));

  // pattern, steps, noisy seed port during run
  localparam int VEC [6][3] = '{'{0, 70, 0}, '{1, 70, 1}, '{2, 20, 0},
                                '{3, 12, 0}, '{4, 8, 0},  '{5, 10, 1}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] seedval(input int pat, input int k);
    case (pat)
      0: return k * 32'h9E3779B9 + 32'h01234567;
      1: return (k * 32'h0019660D + 32'h3C6EF35F) ^ (k << 20);
      2: return 32'hFFFFFFFF;
      3: return (k == 1) ? 32'hABCDEF03 : k * 32'h7F4A7C15 + 32'h55AA0F0F;
      4: return (k == 0) ? 32'h4 : (k == 1) ? 32'h10 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic ref_step(output logic [31:0] r);
    logic [31:0] mx, x, y;
    case (ri % 4)
      0: mx = ra ^ (ra << 13);
      1: mx = ra ^ (ra >> 6);
      2: mx = ra ^ (ra << 2);
      default: mx = ra ^ (ra >> 16);
    endcase
    ra = mx + rm[(ri + 32) % 64];
    x = rm[ri];
    y = rm[x[7:2]] + ra + rb;
    rm[ri] = y;
    rb = rm[y[13:8]] + x;
    r = rb;
    ri = (ri + 1) % 64;
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0; seed_we = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(rnd_valid == 1'b0, "R1 valid in reset", {31'b0, rnd_valid}, 32'h0);
    chk(rnd_data == 32'h0, "R1 data in reset", rnd_data, 32'h0);
    rst_n = 1'b1;
    ra = '0; rb = '0; ri = 0;
  endtask

  task automatic seed_table(input int pat);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      seed_we = 1'b1; seed_addr = 6'(k); seed_data = seedval(pat, k);
      rm[k] = seed_data;
    end
    @(negedge clk);
    seed_we = 1'b0;
  endtask

  task automatic run_steps(input int n, input bit noisy, input string tag, output logic [31:0] first);
    int got = 0;
    int gap = 0;
    int wait_cnt = 0;
    logic [31:0] exp;
    run = 1'b1;
    seed_we = noisy;
    seed_data = 32'hDEADBEEF;
    while (got < n && wait_cnt < 1000) begin
      @(negedge clk);
      gap++; wait_cnt++;
      if (noisy) seed_addr = seed_addr + 6'd7;
      if (rnd_valid) begin
        ref_step(exp);
        if (got == 0) first = rnd_data;
        chk(rnd_data == exp, tag, rnd_data, exp);
        chk(gap == 5, "R4 five-cycle step spacing", 32'(gap), 32'd5);
        got++; gap = 0; wait_cnt = 0;
        if (got == n) begin run = 1'b0; seed_we = 1'b0; end
      end
    end
    if (got < n) chk(1'b0, "R4 result never arrived", 32'(got), 32'(n));
    run = 1'b0; seed_we = 1'b0;
  endtask

  task automatic expect_quiet(input int cycles);
    int seen = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (rnd_valid) seen++;
    end
    chk(seen == 0, "R12 no step while run low", 32'(seen), 32'd0);
  endtask

  initial begin
    #800000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] first;
    string tag;
    for (int v = 0; v < 6; v++) begin
      do_reset();
      seed_table(VEC[v][0]);
      case (VEC[v][0])
        1: tag = "R3 R5 R6 R7 R10 R11 result with seed port noise";
        3: tag = "R8 R6 R7 R10 result with first-lookup forwarding";
        4: tag = "R9 R10 result with second-lookup forwarding";
        default: tag = "R2 R5 R6 R7 R9 R10 R11 result";
      endcase
      run_steps(VEC[v][1], VEC[v][2] != 0, tag, first);
      if (VEC[v][0] == 4) chk(first == 32'h14, "R9 forwarded fresh word", first, 32'h14);
      expect_quiet(12);
    end

    // reset keeps the table, clears index and accumulators
    repeat (3) @(negedge clk);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(rnd_data == 32'h0, "R1 data cleared", rnd_data, 32'h0);
    rst_n = 1'b1; ra = '0; rb = '0; ri = 0;
    run_steps(9, 1'b0, "R1 table retained across reset", first);

    // idle reseed of one entry then resume
    repeat (3) @(negedge clk);
    seed_we = 1'b1; seed_addr = 6'(ri); seed_data = 32'h0BADF00D; rm[ri] = seed_data;
    @(negedge clk); seed_we = 1'b0;
    run_steps(6, 1'b0, "R2 idle single-entry seed", first);

    // run dropped mid-step: step still completes
    @(negedge clk); run = 1'b1;
    @(negedge clk); run = 1'b0;
    begin
      int seen = 0;
      logic [31:0] exp;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (rnd_valid) begin
          seen++;
          ref_step(exp);
          chk(rnd_data == exp, "R12 started step completes", rnd_data, exp);
        end
      end
      chk(seen == 1, "R12 exactly one step", 32'(seen), 32'd1);
    end
    expect_quiet(10);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule